// File: doc/BRIEF.md
# Programmable TFT Panel Sync Timing Generator

This block drives the timing side of an RGB TFT panel from the dot clock. A horizontal dot counter and a vertical line counter run against programmable totals. Sync pulses and a data-enable window are decoded from programmable start and width values, and the pixel stream that the block sends to the panel is shaped on its way through. All settings come from a byte-wide register write port. The ten 12-bit timing values are written into shadow copies. They reach the counters only after a load command, and only at the next frame boundary, so a frame never mixes old and new timing.

On the pixel path the block can substitute three constant test colours for the incoming data and blank the output. It also reorders the three colour components with a per-line code, one code for even lines and one for odd lines. For a parallel panel the reordered components appear on the three colour buses at once. For a serial panel each pixel takes three dot clocks on the first bus. A polarity bit for the panel's dot clock is passed on to the clock tree.

Top module: `tft_sync_timer`

## Requirements
- R1: After reset the active timing holds these values: sync-H start 0, sync-H width 0x10, H-active start 0x38, H-active width 0x140, H total 0x1B8, sync-V start 0, sync-V width 8, V-active start 0x12, V-active width 0xF0, V total 0x109. The control register 0x10 resets to 0x0C. The order register 0x11 and the test colours reset to 0, and `dclk_fall` resets to 0.
- R2: The dot counter runs from 0 to Htotal-1 and then returns to 0. `hsync_n` is low exactly while start <= dot < start+width.
- R3: The line counter advances by one when a line ends and wraps after Vtotal-1. `vsync_n` is low exactly while start <= line < start+width.
- R4: `de` is high exactly when the dot lies inside the H-active window and the line lies inside the V-active window. Each window runs from its start up to, but not including, start+width.
- R5: Timing values are written at addresses 0x12 to 0x25 as high/low byte pairs. The even address of each pair holds bits 11:8 in data bits 3:0, and the following odd address holds bits 7:0. The pairs in address order are: sync-H start, sync-H width, H-active start, H-active width, H total, sync-V start, sync-V width, V-active start, V-active width, V total. These writes change nothing on the outputs until a load is requested, and writing 0x29 with bit 0 clear requests no load.
- R6: Writing 0x29 with bit 0 set copies all ten shadow values into the active timing on the clock edge where the frame wraps from the last dot of the last line to dot 0 of line 0.
- R7: When bit 3 of register 0x10 is 0, the colour outputs are 0. When it is 1, they carry data.
- R8: When bit 6 of register 0x10 is 1, the red, green and blue sources are bits 6:0 of registers 0x2A, 0x2B and 0x2C instead of the pixel inputs.
- R9: Register 0x11 bits 5:3 give the order for even lines and bits 2:0 the order for odd lines. The codes are: 0 RGB, 1 RBG, 2 GRB, 3 GBR, 4 BRG, 5 BGR. Codes 6 and 7 act as RGB. In parallel mode (0x10 bit 2 = 1), the first, second and third components of the order appear on `out_r`, `out_g` and `out_b`.
- R10: In serial mode (0x10 bit 2 = 0), `out_g` and `out_b` are 0. `out_r` shows the first, second and third ordered components on consecutive active dots, and the cycle restarts at the first active dot of each line.
- R11: `dclk_fall` follows bit 2 of the last value written to register 0x2D.
- R12: The colour outputs are 0 whenever `de` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| pix_r | input | COLOR_W | Red pixel data from the frame source |
| pix_g | input | COLOR_W | Green pixel data |
| pix_b | input | COLOR_W | Blue pixel data |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Data enable |
| out_r | output | COLOR_W | Panel colour bus 0 (serial stream in serial mode) |
| out_g | output | COLOR_W | Panel colour bus 1 |
| out_b | output | COLOR_W | Panel colour bus 2 |
| dclk_fall | output | 1 | Panel clock polarity select |

## Verification
The bench compares every output on every dot against a model it keeps itself. That model is built first with the reset timing, which shows that the defaults and the full-size counters are right. It is then built with random small timings in which windows may reach past the totals or have zero width, which separates the inclusive and exclusive window bounds and exposes the wrap rules. Random colour-order codes, including the reserved ones, are applied on alternating lines in both panel modes. These tell an even/odd swap, a wrong permutation and a serial phase that fails to restart apart. Shadow writes are made without a load and loads are made in the middle of a frame, which shows whether a commit happens early or is lost.

// File: rtl/tft_tg_pkg.sv
package tft_tg_pkg;

    localparam int TW     = 12;
    localparam int NFIELD = 10;

    typedef logic [TW-1:0] tval_t;

    typedef struct packed {
        tval_t hs_st;
        tval_t hs_w;
        tval_t hde_st;
        tval_t hde_w;
        tval_t htot;
        tval_t vs_st;
        tval_t vs_w;
        tval_t vde_st;
        tval_t vde_w;
        tval_t vtot;
    } timing_t;

    typedef enum logic [2:0] {
        ORD_RGB = 3'd0,
        ORD_RBG = 3'd1,
        ORD_GRB = 3'd2,
        ORD_GBR = 3'd3,
        ORD_BRG = 3'd4,
        ORD_BGR = 3'd5
    } order_e;

    localparam logic [7:0] A_TIM_FIRST = 8'h12;
    localparam logic [7:0] A_TIM_LAST  = 8'h25;
    localparam logic [7:0] A_LOAD      = 8'h29;
    localparam logic [7:0] A_CTRL      = 8'h10;
    localparam logic [7:0] A_ORDER     = 8'h11;
    localparam logic [7:0] A_TP_R      = 8'h2A;
    localparam logic [7:0] A_TP_G      = 8'h2B;
    localparam logic [7:0] A_TP_B      = 8'h2C;
    localparam logic [7:0] A_CLKPOL    = 8'h2D;

    localparam int CB_PAR  = 2;
    localparam int CB_NORM = 3;
    localparam int CB_TEST = 6;

    // reset value of each timing field, in register-pair order
    function automatic tval_t field_default(input int idx);
        case (idx)
            1:       return 12'h010;
            2:       return 12'h038;
            3:       return 12'h140;
            4:       return 12'h1B8;
            6:       return 12'h008;
            7:       return 12'h012;
            8:       return 12'h0F0;
            9:       return 12'h109;
            default: return 12'h000;
        endcase
    endfunction

    // component index (0=R,1=G,2=B) sent in slot 0,1,2
    function automatic logic [2:0][1:0] order_sel(input logic [2:0] code);
        logic [2:0][1:0] s;
        case (order_e'(code))
            ORD_RBG: s = '{2'd1, 2'd2, 2'd0};
            ORD_GRB: s = '{2'd2, 2'd0, 2'd1};
            ORD_GBR: s = '{2'd0, 2'd2, 2'd1};
            ORD_BRG: s = '{2'd1, 2'd0, 2'd2};
            ORD_BGR: s = '{2'd0, 2'd1, 2'd2};
            default: s = '{2'd2, 2'd1, 2'd0};
        endcase
        return s;
    endfunction

    function automatic logic in_window(input tval_t c, input tval_t st, input tval_t w);
        logic [TW:0] stop;
        stop = {1'b0, st} + {1'b0, w};
        return (c >= st) && ({1'b0, c} < stop);
    endfunction

endpackage

// File: rtl/tft_tg_regs.sv
module tft_tg_regs
    import tft_tg_pkg::*;
#(
    parameter int COLOR_W = 7
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        we,
    input  logic [7:0]                  addr,
    input  logic [7:0]                  wdata,
    input  logic                        frame_wrap,
    output timing_t                     tim_o,
    output logic                        par_o,
    output logic                        norm_o,
    output logic                        test_o,
    output logic                        dclk_fall_o,
    output logic [2:0]                  ord_even_o,
    output logic [2:0]                  ord_odd_o,
    output logic [2:0][COLOR_W-1:0]     tp_o
);

    localparam int HI_W = TW - 8;

    tval_t       sh  [NFIELD];
    tval_t       act [NFIELD];
    logic        pend;
    logic        tim_hit;
    logic        hi_byte;
    logic [7:0]  off;
    int          idx;
    logic        load_wr;

    always_comb begin
        off     = addr - A_TIM_FIRST;
        idx     = int'(off[7:1]);
        tim_hit = we && (addr >= A_TIM_FIRST) && (addr <= A_TIM_LAST);
        hi_byte = ~off[0];
        load_wr = we && (addr == A_LOAD) && wdata[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NFIELD; i++) begin
                sh[i]  <= field_default(i);
                act[i] <= field_default(i);
            end
            pend        <= 1'b0;
            par_o       <= 1'b1;
            norm_o      <= 1'b1;
            test_o      <= 1'b0;
            dclk_fall_o <= 1'b0;
            ord_even_o  <= 3'd0;
            ord_odd_o   <= 3'd0;
            tp_o        <= '0;
        end else begin
            if (tim_hit) begin
                if (hi_byte) sh[idx][TW-1:8] <= wdata[HI_W-1:0];
                else         sh[idx][7:0]    <= wdata;
            end
            if (we) begin
                case (addr)
                    A_CTRL: begin
                        par_o  <= wdata[CB_PAR];
                        norm_o <= wdata[CB_NORM];
                        test_o <= wdata[CB_TEST];
                    end
                    A_ORDER: begin
                        ord_even_o <= wdata[5:3];
                        ord_odd_o  <= wdata[2:0];
                    end
                    A_TP_R:   tp_o[0]     <= wdata[COLOR_W-1:0];
                    A_TP_G:   tp_o[1]     <= wdata[COLOR_W-1:0];
                    A_TP_B:   tp_o[2]     <= wdata[COLOR_W-1:0];
                    A_CLKPOL: dclk_fall_o <= wdata[2];
                    default: ;
                endcase
            end
            if (pend && frame_wrap) begin
                for (int i = 0; i < NFIELD; i++) act[i] <= sh[i];
            end
            if (load_wr)         pend <= 1'b1;
            else if (frame_wrap) pend <= 1'b0;
        end
    end

    always_comb begin
        tim_o.hs_st  = act[0];
        tim_o.hs_w   = act[1];
        tim_o.hde_st = act[2];
        tim_o.hde_w  = act[3];
        tim_o.htot   = act[4];
        tim_o.vs_st  = act[5];
        tim_o.vs_w   = act[6];
        tim_o.vde_st = act[7];
        tim_o.vde_w  = act[8];
        tim_o.vtot   = act[9];
    end

    // R6
    commit_at_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_wrap |=> $stable(tim_o));

    // R5
    no_pend_no_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (!pend && !load_wr) |=> $stable(tim_o));

endmodule

// File: rtl/tft_tg_counter.sv
module tft_tg_counter
    import tft_tg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  timing_t tim,
    output tval_t   hcnt,
    output tval_t   vcnt,
    output logic    line_end,
    output logic    frame_wrap
);

    logic v_last;

    always_comb begin
        line_end   = ({1'b0, hcnt} + 13'd1) >= {1'b0, tim.htot};
        v_last     = ({1'b0, vcnt} + 13'd1) >= {1'b0, tim.vtot};
        frame_wrap = line_end && v_last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt <= '0;
            vcnt <= '0;
        end else if (line_end) begin
            hcnt <= '0;
            vcnt <= v_last ? '0 : vcnt + 1'b1;
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

    // R2
    hcnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        (tim.htot != '0) |-> (hcnt < tim.htot));

    // R3
    vcnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !line_end |=> $stable(vcnt));

    // R3
    vcnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        (tim.vtot != '0) |-> (vcnt < tim.vtot));

endmodule

// File: rtl/tft_tg_pixmux.sv
module tft_tg_pixmux
    import tft_tg_pkg::*;
#(
    parameter int COLOR_W = 7
) (
    input  logic                    clk,
    input  logic                    rst,
    input  timing_t                 tim,
    input  tval_t                   hcnt,
    input  tval_t                   vcnt,
    input  logic                    par,
    input  logic                    norm,
    input  logic                    test,
    input  logic [2:0]              ord_even,
    input  logic [2:0]              ord_odd,
    input  logic [2:0][COLOR_W-1:0] tp,
    input  logic [2:0][COLOR_W-1:0] pix,
    output logic                    hsync_n,
    output logic                    vsync_n,
    output logic                    de,
    output logic [2:0][COLOR_W-1:0] out
);

    logic [1:0]               ph;
    logic [2:0][COLOR_W-1:0]  src;
    logic [2:0][COLOR_W-1:0]  slot;
    logic [2:0][1:0]          sel;
    logic                     pass;

    always_comb begin
        hsync_n = ~in_window(hcnt, tim.hs_st, tim.hs_w);
        vsync_n = ~in_window(vcnt, tim.vs_st, tim.vs_w);
        de      = in_window(hcnt, tim.hde_st, tim.hde_w) &&
                  in_window(vcnt, tim.vde_st, tim.vde_w);
        src     = test ? tp : pix;
        sel     = order_sel(vcnt[0] ? ord_odd : ord_even);
        pass    = de && norm;
    end

    for (genvar k = 0; k < 3; k++) begin : g_slot
        assign slot[k] = src[sel[k]];
    end

    always_comb begin
        out = '0;
        if (pass) begin
            if (par) out = slot;
            else     out[0] = slot[ph];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       ph <= 2'd0;
        else if (!de)  ph <= 2'd0;
        else           ph <= (ph == 2'd2) ? 2'd0 : ph + 2'd1;
    end

    // R12
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !de |-> (out == '0));

    // R10
    serial_side_chk: assert property (@(posedge clk) disable iff (rst)
        !par |-> (out[1] == '0 && out[2] == '0));

    // R10
    phase_range_chk: assert property (@(posedge clk) disable iff (rst)
        ph != 2'd3);

    // R7
    blank_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !norm |-> (out == '0));

endmodule

// File: rtl/tft_sync_timer.sv
module tft_sync_timer
    import tft_tg_pkg::*;
#(
    parameter int COLOR_W = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic [7:0]         reg_addr,
    input  logic [7:0]         reg_wdata,
    input  logic [COLOR_W-1:0] pix_r,
    input  logic [COLOR_W-1:0] pix_g,
    input  logic [COLOR_W-1:0] pix_b,
    output logic               hsync_n,
    output logic               vsync_n,
    output logic               de,
    output logic [COLOR_W-1:0] out_r,
    output logic [COLOR_W-1:0] out_g,
    output logic [COLOR_W-1:0] out_b,
    output logic               dclk_fall
);

    timing_t                 tim;
    tval_t                   hcnt;
    tval_t                   vcnt;
    logic                    line_end;
    logic                    frame_wrap;
    logic                    par;
    logic                    norm;
    logic                    test;
    logic [2:0]              ord_even;
    logic [2:0]              ord_odd;
    logic [2:0][COLOR_W-1:0] tp;
    logic [2:0][COLOR_W-1:0] pix;
    logic [2:0][COLOR_W-1:0] out;

    assign pix   = {pix_b, pix_g, pix_r};
    assign out_r = out[0];
    assign out_g = out[1];
    assign out_b = out[2];

    tft_tg_regs #(.COLOR_W(COLOR_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .we          (reg_we),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .frame_wrap  (frame_wrap),
        .tim_o       (tim),
        .par_o       (par),
        .norm_o      (norm),
        .test_o      (test),
        .dclk_fall_o (dclk_fall),
        .ord_even_o  (ord_even),
        .ord_odd_o   (ord_odd),
        .tp_o        (tp)
    );

    tft_tg_counter u_cnt (
        .clk        (clk),
        .rst        (rst),
        .tim        (tim),
        .hcnt       (hcnt),
        .vcnt       (vcnt),
        .line_end   (line_end),
        .frame_wrap (frame_wrap)
    );

    tft_tg_pixmux #(.COLOR_W(COLOR_W)) u_pix (
        .clk      (clk),
        .rst      (rst),
        .tim      (tim),
        .hcnt     (hcnt),
        .vcnt     (vcnt),
        .par      (par),
        .norm     (norm),
        .test     (test),
        .ord_even (ord_even),
        .ord_odd  (ord_odd),
        .tp       (tp),
        .pix      (pix),
        .hsync_n  (hsync_n),
        .vsync_n  (vsync_n),
        .de       (de),
        .out      (out)
    );

endmodule

// File: tb/tb_tft_sync_timer.sv
module tb_tft_sync_timer;

    localparam int CLK_PERIOD = 10;
    localparam int CW         = 7;
    localparam int WATCHDOG   = 195000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_we = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic [CW-1:0] pix_r = '0, pix_g = '0, pix_b = '0;
    logic          hsync_n, vsync_n, de, dclk_fall;
    logic [CW-1:0] out_r, out_g, out_b;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 1'b0;
    string cur_tag = "R1";

    tft_sync_timer #(.COLOR_W(CW)) dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de),
        .out_r(out_r), .out_g(out_g), .out_b(out_b), .dclk_fall(dclk_fall)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- bench model, built from the requirements ----------------
    logic [11:0] m_sh  [10];
    logic [11:0] m_act [10];
    logic        m_pend;
    logic [11:0] m_h, m_v;
    logic [1:0]  m_ph;
    logic        m_par, m_norm, m_test, m_fall;
    logic [2:0]  m_oe, m_oo;
    logic [CW-1:0] m_tp [3];
    int          m_frames;

    function automatic logic [11:0] dflt(input int i);
        logic [11:0] t [10] = '{12'h000, 12'h010, 12'h038, 12'h140, 12'h1B8,
                                12'h000, 12'h008, 12'h012, 12'h0F0, 12'h109};
        return t[i];
    endfunction

    function automatic bit win(input logic [11:0] c, input logic [11:0] st, input logic [11:0] w);
        return (int'(c) >= int'(st)) && (int'(c) < int'(st) + int'(w));
    endfunction

    function automatic int comp_of(input logic [2:0] code, input int slot);
        int t [6][3] = '{'{0,1,2}, '{0,2,1}, '{1,0,2}, '{1,2,0}, '{2,0,1}, '{2,1,0}};
        if (code > 3'd5) return slot;
        return t[code][slot];
    endfunction

    function automatic bit m_de_now();
        return win(m_h, m_act[2], m_act[3]) && win(m_v, m_act[7], m_act[8]);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 10; i++) begin m_sh[i] = dflt(i); m_act[i] = dflt(i); end
            m_pend = 0; m_h = 0; m_v = 0; m_ph = 0;
            m_par = 1; m_norm = 1; m_test = 0; m_fall = 0;
            m_oe = 0; m_oo = 0; m_tp[0] = 0; m_tp[1] = 0; m_tp[2] = 0;
            m_frames = 0;
        end else begin
            bit lend, vlast, wrap, dnow;
            lend  = int'(m_h) + 1 >= int'(m_act[4]);
            vlast = int'(m_v) + 1 >= int'(m_act[9]);
            wrap  = lend && vlast;
            dnow  = m_de_now();
            m_ph  = !dnow ? 2'd0 : (m_ph == 2'd2 ? 2'd0 : m_ph + 2'd1);
            if (lend) begin m_h = 0; m_v = vlast ? 12'd0 : m_v + 12'd1; end
            else m_h = m_h + 12'd1;
            if (wrap) m_frames++;
            if (wrap && m_pend) for (int i = 0; i < 10; i++) m_act[i] = m_sh[i];
            if (reg_we && reg_addr == 8'h29 && reg_wdata[0]) m_pend = 1;
            else if (wrap) m_pend = 0;
            if (reg_we) begin
                if (reg_addr >= 8'h12 && reg_addr <= 8'h25) begin
                    int ix;
                    ix = int'(reg_addr - 8'h12) / 2;
                    if (reg_addr[0] == 1'b0) m_sh[ix][11:8] = reg_wdata[3:0];
                    else                     m_sh[ix][7:0]  = reg_wdata;
                end
                case (reg_addr)
                    8'h10: begin m_par = reg_wdata[2]; m_norm = reg_wdata[3]; m_test = reg_wdata[6]; end
                    8'h11: begin m_oe = reg_wdata[5:3]; m_oo = reg_wdata[2:0]; end
                    8'h2A: m_tp[0] = reg_wdata[CW-1:0];
                    8'h2B: m_tp[1] = reg_wdata[CW-1:0];
                    8'h2C: m_tp[2] = reg_wdata[CW-1:0];
                    8'h2D: m_fall = reg_wdata[2];
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            if (errors < 30)
                $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cycles, act, exp);
        end
    endtask

    // per-dot comparison, away from the active edge; pixel inputs change afterwards
    always @(negedge clk) begin
        cycles++;
        if (!rst && !done) begin
            logic [CW-1:0] src [3];
            logic [CW-1:0] er, eg, eb;
            bit dn;
            logic [2:0] code;
            dn = m_de_now();
            chk("R2 hsync_n", hsync_n, !win(m_h, m_act[0], m_act[1]));
            chk("R3 vsync_n", vsync_n, !win(m_v, m_act[5], m_act[6]));
            chk("R4 de", de, dn);
            src[0] = m_test ? m_tp[0] : pix_r;
            src[1] = m_test ? m_tp[1] : pix_g;
            src[2] = m_test ? m_tp[2] : pix_b;
            code = m_v[0] ? m_oo : m_oe;
            er = 0; eg = 0; eb = 0;
            if (dn && m_norm) begin
                if (m_par) begin
                    er = src[comp_of(code, 0)];
                    eg = src[comp_of(code, 1)];
                    eb = src[comp_of(code, 2)];
                end else begin
                    er = src[comp_of(code, int'(m_ph))];
                end
            end
            chk({cur_tag, " out_r"}, out_r, er);
            chk({cur_tag, " out_g"}, out_g, eg);
            chk({cur_tag, " out_b"}, out_b, eb);
            pix_r = CW'($urandom); pix_g = CW'($urandom); pix_b = CW'($urandom);
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wr12(input int field, input int val);
        wr(8'(8'h12 + 2*field), {4'h0, 4'(val >> 8)});
        wr(8'(8'h13 + 2*field), 8'(val));
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_commit();
        int g = 0;
        while (m_pend && g < 130000) begin @(negedge clk); g++; end
    endtask

    task automatic set_timing(input int v [10]);
        for (int i = 0; i < 10; i++) wr12(i, v[i]);
    endtask

    task automatic wait_frames(input int n);
        int start = m_frames;
        int g = 0;
        while (m_frames < start + n && g < 20000) begin @(negedge clk); g++; end
    endtask

    initial begin
        void'($urandom(32'd4711));
        run(4);
        @(negedge clk); rst = 1'b0;
        // R1: reset state on the ports
        chk("R1 hsync_n at reset", hsync_n, 1'b0);
        chk("R1 vsync_n at reset", vsync_n, 1'b0);
        chk("R11 dclk_fall at reset", dclk_fall, 1'b0);
        chk("R12 de at reset", de, 1'b0);
        run(8500);

        // R5: shadow writes without load
        cur_tag = "R5";
        set_timing('{2, 3, 6, 12, 24, 1, 2, 3, 5, 10});
        run(1500);
        wr(8'h29, 8'h00);
        run(1500);
        chk("R5 no pending load after bit0=0", m_pend, 1'b0);

        // R6: load waits for frame end
        cur_tag = "R6";
        wr(8'h29, 8'h01);
        wait_commit();
        run(5);
        chk("R6 new line length in effect", m_act[4], 12'd24);

        // R9: colour order, parallel
        cur_tag = "R9";
        for (int k = 0; k < 8; k++) begin
            wr(8'h11, 8'($urandom_range(0, 63)));
            wait_frames(1);
        end
        wr(8'h11, {2'b00, 3'd5, 3'd7});
        wait_frames(1);

        // R8: test colours
        cur_tag = "R8";
        wr(8'h2A, 8'($urandom)); wr(8'h2B, 8'($urandom)); wr(8'h2C, 8'($urandom));
        wr(8'h10, 8'h4C);
        wait_frames(2);

        // R7: blanking
        cur_tag = "R7";
        wr(8'h10, 8'h44);
        wait_frames(1);
        wr(8'h10, 8'h0C);

        // R10: serial stream
        cur_tag = "R10";
        wr(8'h10, 8'h08);
        for (int k = 0; k < 5; k++) begin
            wr(8'h11, 8'($urandom_range(0, 63)));
            wait_frames(1);
        end
        wr(8'h10, 8'h48);
        wait_frames(1);
        wr(8'h10, 8'h0C);

        // R11: clock polarity
        wr(8'h2D, 8'h04);
        chk("R11 dclk_fall set", dclk_fall, 1'b1);
        wr(8'h2D, 8'hFB);
        chk("R11 dclk_fall clear", dclk_fall, 1'b0);

        // R12: zero-width active window, data must stay 0
        cur_tag = "R12";
        set_timing('{0, 0, 4, 0, 16, 0, 0, 1, 4, 6});
        wr(8'h29, 8'h01);
        wait_commit();
        wait_frames(2);

        // R2/R3/R4: random timings, windows may overrun totals
        cur_tag = "R4";
        for (int k = 0; k < 8; k++) begin
            int ht, vt;
            ht = $urandom_range(6, 40);
            vt = $urandom_range(3, 14);
            set_timing('{$urandom_range(0, ht), $urandom_range(0, ht), $urandom_range(0, ht),
                         $urandom_range(0, ht), ht,
                         $urandom_range(0, vt), $urandom_range(0, vt), $urandom_range(0, vt),
                         $urandom_range(0, vt), vt});
            wr(8'h11, 8'($urandom_range(0, 63)));
            wr(8'h10, $urandom_range(0, 1) ? 8'h0C : 8'h08);
            wr(8'h29, 8'h01);
            wait_commit();
            wait_frames(3);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        run(WATCHDOG);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule